// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous static memory. Its word is 36 bits wide, made of four 9-bit bytes, and its depth is a parameter. Address and control are registered on the rising clock edge. Every access has its data phase exactly two enabled clock edges after its command, whether it is a read or a write. Because of this, reads and writes can be issued on consecutive cycles in any mix, and the data bus never needs an idle cycle to turn around.

A command is either a load, which takes a fresh address and direction, or an advance, which steps a 2-bit burst counter inside the current aligned group of four words. The counter can step in linear or interleaved order. A clock enable freezes the whole block for as long as it is high. Three chip selects, two active low and one active high, gate the loads. Each byte has its own active-low write mask. An output enable gates the read driver without waiting for a clock edge.

The bidirectional bus is split into a data-in port, a data-out port and a driver-enable output. A pad ring outside the block joins them into one bus.

Top module: `zbt_sram`

## Requirements
- R1: When clock enable is low and load_n is low with the chip selected on a rising edge, the address and direction are captured. A read (wr_rd=1) drives the word stored at that address on dout with dout_oe=1 after the second enabled edge that follows the command edge, and holds it for one enabled cycle.
- R2: A write (wr_rd=0) takes din at the second enabled edge after its command. It stores byte i (bits 9i+8 down to 9i) only where byte_wen_n[i] was 0 at the command edge. dout_oe is low during a write's data phase.
- R3: Reads and writes can be issued on consecutive enabled cycles in any order. A read that follows a write to the same address returns the newly written bytes.
- R4: With load_n high during an active burst, the address input and wr_rd are ignored. The next beat keeps the upper address bits of the loaded address, and its two low bits are (start + n) mod 4 while seq_xor=0, where n is the beat number (1, 2, 3, 4, ...).
- R5: While seq_xor=1, the low two bits of beat n are start XOR (n mod 4).
- R6: Each write beat of a burst uses the byte_wen_n value sampled on that beat's own command edge.
- R7: The chip is selected only when sel_a_n=0, sel_b_n=0 and sel_hi=1. A load without selection is a deselect: dout_oe is low two enabled edges later, and it ends any burst, so a following advance does nothing.
- R8: An edge at which clk_en_n is high is ignored. Nothing is sampled, the pipeline holds, and dout and dout_oe keep their values.
- R9: out_en_n high forces dout_oe low at once, with no clock edge needed. Taking it low again restores the driver state of the pipeline.
- R10: After reset, dout_oe stays low until the first read reaches its data phase.
- R11: byte_wen_n is ignored on reads, so the full 36-bit word is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline and the burst state |
| clk_en_n | input | 1 | Active-low clock enable; when high, the edge is ignored |
| load_n | input | 1 | Low loads a new command; high advances the current burst |
| wr_rd | input | 1 | 1 = read, 0 = write; sampled on loads only |
| addr | input | AW | Word address |
| byte_wen_n | input | 4 | Active-low byte write masks |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Second active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| seq_xor | input | 1 | Burst order: 1 interleaved, 0 linear; kept static |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| din | input | 36 | Write data, taken in the data phase |
| dout | output | 36 | Read data |
| dout_oe | output | 1 | Read-data driver enable |

## Verification
The hardest situation to reach is a clock-enable stall that lands while a mixed burst and a write-then-read to the same word are still inside the two-stage pipeline. Here the held edge must delay the data phase and must not drop it. The stimulus loads a write, follows it with a read of the same address, and then issues an interleaved read burst. It inserts high clock-enable cycles between the beats and toggles the output enable during a driven beat. A behavioural queue model predicts dout and dout_oe on every cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int BYTE_W  = 9;
    localparam int N_BYTES = 4;
    localparam int WORD_W  = BYTE_W * N_BYTES;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;
endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
    import zbt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load_n,
    input  logic          sel,
    input  logic          wr_rd,
    input  logic          seq_xor,
    input  logic [AW-1:0] addr,
    output op_kind_e      op_kind,
    output logic [AW-1:0] op_addr
);
    typedef struct packed {
        logic          active;
        logic          is_wr;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        logic [1:0] nxt;
        logic [1:0] off;
        st_d    = st_q;
        op_kind = OP_IDLE;
        op_addr = st_q.base;
        nxt     = st_q.cnt + 2'd1;
        off     = seq_xor ? (st_q.base[1:0] ^ nxt) : (st_q.base[1:0] + nxt);
        if (!load_n) begin
            if (sel) begin
                st_d.active = 1'b1;
                st_d.is_wr  = ~wr_rd;
                st_d.base   = addr;
                st_d.cnt    = 2'd0;
                op_kind     = wr_rd ? OP_READ : OP_WRITE;
                op_addr     = addr;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            st_d.cnt = nxt;
            op_kind  = st_q.is_wr ? OP_WRITE : OP_READ;
            op_addr  = {st_q.base[AW-1:2], off};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (en) begin
            st_q <= st_d;
        end
    end

    AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load_n && !sel) |=> !st_q.active) else $error("burst survived deselect"); // R7

    AST_GROUP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load_n && st_q.active) |=> (st_q.base == $past(st_q.base))) else $error("burst base moved"); // R4
endmodule

// File: rtl/zbt_store.sv
module zbt_store
    import zbt_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [N_BYTES-1:0] be,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && be[b]) begin
                mem_q[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              load_n,
    input  logic              wr_rd,
    input  logic [AW-1:0]     addr,
    input  logic [3:0]        byte_wen_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_hi,
    input  logic              seq_xor,
    input  logic              out_en_n,
    input  logic [35:0]       din,
    output logic [35:0]       dout,
    output logic              dout_oe
);
    typedef struct packed {
        op_kind_e          kind;
        logic [AW-1:0]     addr;
        logic [N_BYTES-1:0] be;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        stage_t            s2;
        logic [WORD_W-1:0] dout;
        logic              drive;
    } pipe_t;

    pipe_t p_d, p_q;

    logic              en;
    logic              sel;
    op_kind_e          cmd_kind;
    logic [AW-1:0]     cmd_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_rdata;

    assign en  = ~clk_en_n;
    assign sel = ~sel_a_n & ~sel_b_n & sel_hi;

    zbt_burst_gen #(.AW(AW)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load_n  (load_n),
        .sel     (sel),
        .wr_rd   (wr_rd),
        .seq_xor (seq_xor),
        .addr    (addr),
        .op_kind (cmd_kind),
        .op_addr (cmd_addr)
    );

    assign mem_we = en && (p_q.s2.kind == OP_WRITE);

    zbt_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .be    (p_q.s2.be),
        .waddr (p_q.s2.addr),
        .wdata (din),
        .raddr (p_q.s2.addr),
        .rdata (mem_rdata)
    );

    always_comb begin
        p_d         = p_q;
        p_d.s1.kind = cmd_kind;
        p_d.s1.addr = cmd_addr;
        p_d.s1.be   = ~byte_wen_n;
        p_d.s2      = p_q.s1;
        p_d.drive   = 1'b0;
        if (p_q.s2.kind == OP_READ) begin
            p_d.dout  = mem_rdata;
            p_d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else if (en) begin
            p_q <= p_d;
        end
    end

    assign dout    = p_q.dout;
    assign dout_oe = p_q.drive & ~out_en_n;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(p_q.dout) && $stable(p_q.drive))) else $error("stall changed output"); // R8

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && p_q.s2.kind == OP_READ) |=> p_q.drive) else $error("read not driven"); // R1

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && p_q.s2.kind == OP_WRITE) |=> !p_q.drive) else $error("write phase drove bus"); // R2

    AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && p_q.s2.kind == OP_IDLE) |=> !p_q.drive) else $error("idle phase drove bus"); // R7

    AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (p_q.s2 == $past(p_q.s1))) else $error("pipeline skipped"); // R3
endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        load_n = 1'b1;
    logic        wr_rd = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]  byte_wen_n = 4'hF;
    logic        sel_a_n = 1'b0;
    logic        sel_b_n = 1'b0;
    logic        sel_hi = 1'b1;
    logic        seq_xor = 1'b0;
    logic        out_en_n = 1'b0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_oe;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    always #2.5 clk = ~clk;

    zbt_sram #(.DEPTH(64)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
        .wr_rd(wr_rd), .addr(addr), .byte_wen_n(byte_wen_n),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_hi(sel_hi),
        .seq_xor(seq_xor), .out_en_n(out_en_n), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    // behavioural reference: 0 idle, 1 read, 2 write
    typedef struct { int kind; int a; logic [3:0] be; } op_t;
    op_t         q[$];
    logic [35:0] m_mem [64];
    logic        m_act = 0, m_wr = 0;
    int          m_base = 0, m_cnt = 0;
    logic        exp_drive = 0;
    logic [35:0] exp_dout = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_act = 0; exp_drive = 0;
        end else if (!clk_en_n) begin
            op_t o;
            o.kind = 0; o.a = 0; o.be = ~byte_wen_n;
            if (!load_n) begin
                if (!sel_a_n && !sel_b_n && sel_hi) begin
                    m_act = 1; m_wr = !wr_rd; m_base = addr; m_cnt = 0;
                    o.kind = wr_rd ? 1 : 2; o.a = addr;
                end else m_act = 0;
            end else if (m_act) begin
                m_cnt = (m_cnt + 1) % 4;
                o.kind = m_wr ? 2 : 1;
                o.a = (m_base / 4) * 4 +
                      (seq_xor ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4));
            end
            q.push_back(o);
            if (q.size() > 2) begin
                op_t d;
                d = q.pop_front();
                exp_drive = (d.kind == 1);
                if (d.kind == 1) exp_dout = m_mem[d.a];
                if (d.kind == 2)
                    for (int b = 0; b < 4; b++)
                        if (d.be[b]) m_mem[d.a][b*9 +: 9] = din[b*9 +: 9];
            end
        end
    end

    task automatic check_out();
        logic eo;
        eo = exp_drive & ~out_en_n;
        checks++;
        if (dout_oe !== eo) begin
            errors++;
            $display("FAIL %s dout_oe actual %b expected %b", cur_req, dout_oe, eo);
        end else if (eo && dout !== exp_dout) begin
            errors++;
            $display("FAIL %s dout actual %h expected %h", cur_req, dout, exp_dout);
        end
    endtask

    task automatic step(input logic ld, input logic rd, input int a,
                        input logic [3:0] bw, input logic s = 1, input logic stall = 0);
        @(negedge clk);
        check_out();
        load_n = ld; wr_rd = rd; addr = AW'(a); byte_wen_n = bw;
        sel_hi = s; clk_en_n = stall;
        din = {4'($urandom), 32'($urandom)};
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 63, 4'hF, 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R10";
        nop(3);
        // fill words 0..15 with full writes
        cur_req = "R2";
        for (int i = 0; i < 16; i++) step(0, 0, i, 4'h0);
        nop(2);
        cur_req = "R1";
        for (int i = 0; i < 8; i++) step(0, 1, i, 4'hF);
        nop(2);
        cur_req = "R11";
        step(0, 1, 3, 4'b0101); step(0, 1, 4, 4'b0000);
        nop(2);
        cur_req = "R2";
        step(0, 0, 5, 4'b1010); step(0, 0, 6, 4'b0111);
        nop(2);
        step(0, 1, 5, 4'hF); step(0, 1, 6, 4'hF);
        nop(2);
        cur_req = "R3";
        step(0, 0, 9, 4'h0); step(0, 1, 9, 4'hF); step(0, 0, 10, 4'hC);
        step(0, 1, 10, 4'hF); step(0, 1, 9, 4'hF); step(0, 0, 9, 4'h3);
        step(0, 1, 9, 4'hF);
        nop(2);
        cur_req = "R4";
        seq_xor = 0;
        step(0, 1, 6, 4'hF);
        for (int i = 0; i < 5; i++) step(1, 0, 40, 4'h0);
        nop(2);
        cur_req = "R5";
        seq_xor = 1;
        step(0, 1, 13, 4'hF);
        for (int i = 0; i < 5; i++) step(1, 0, 50, 4'h0);
        nop(2);
        cur_req = "R6";
        seq_xor = 0;
        step(0, 0, 2, 4'hE);
        step(1, 1, 0, 4'hD); step(1, 1, 0, 4'hB); step(1, 1, 0, 4'h7);
        nop(2);
        step(0, 1, 0, 4'hF); step(1, 1, 0, 4'hF); step(1, 1, 0, 4'hF); step(1, 1, 0, 4'hF);
        nop(2);
        cur_req = "R7";
        step(0, 1, 1, 4'hF);
        step(1, 1, 0, 4'hF);
        @(negedge clk); check_out();
        load_n = 0; sel_a_n = 1; sel_hi = 1; clk_en_n = 0;
        @(negedge clk); check_out();
        sel_a_n = 0; sel_b_n = 1; load_n = 1;
        @(negedge clk); check_out();
        sel_b_n = 0;
        step(1, 1, 0, 4'hF); step(1, 1, 0, 4'hF);
        step(0, 1, 7, 4'hF, 0);
        nop(3);
        cur_req = "R8";
        seq_xor = 1;
        step(0, 0, 12, 4'h0); step(0, 1, 12, 4'hF);
        step(0, 1, 14, 4'hF, 1, 1); step(0, 1, 14, 4'hF, 1, 1);
        step(0, 1, 14, 4'hF, 1, 0);
        step(1, 0, 0, 4'h0, 1, 1); step(1, 0, 0, 4'h0, 1, 0);
        step(1, 0, 0, 4'h0, 1, 1); step(1, 0, 0, 4'h0, 1, 1);
        step(1, 1, 0, 4'hF, 1, 0); step(1, 1, 0, 4'hF, 1, 0);
        nop(3);
        cur_req = "R9";
        step(0, 1, 8, 4'hF); nop(2);
        @(negedge clk); check_out();
        out_en_n = 1; #0.5;
        checks++;
        if (dout_oe !== 1'b0) begin
            errors++;
            $display("FAIL R9 dout_oe actual %b expected 0", dout_oe);
        end
        out_en_n = 0; #0.5;
        checks++;
        if (dout_oe !== 1'b1) begin
            errors++;
            $display("FAIL R9 dout_oe actual %b expected 1", dout_oe);
        end
        nop(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule